// File: doc/BRIEF.md
# Instruction issue exception checker

This block sits at the issue point of a pipeline and inspects each decoded instruction before it executes. It takes the instruction's attribute bits (bundle constraint violation, non-excepting form, conditional form, floating-point, media, media trap, FP-register access, privileged) together with the current mode enables (non-excepting mode, conditional mode, FP unit, media unit, supervisor). It decides in a single combinational pass which one issue-time fault, if any, the instruction raises.

The checks form a fixed priority chain, and only the first check that matches takes effect. A fault that means "not implemented" is turned into a floating-point trap, an illegal-instruction trap or a media status update. Which one depends on the instruction type and on the core variant: a full core or a reduced core that lacks the FP and media exception paths. The media status update writes the media trap-type field and raises no trap. That field is written only while it is empty. The trap queue and handler dispatch sit downstream and are not part of this block.

Top module: `issue_exc_check`

## Requirements
- R1: The checks are applied in this priority order and only the first matching one acts: bundle constraint violation; non-excepting instruction with non-excepting mode off, or conditional instruction with conditional mode off (both "not implemented"); FP unit disabled; media unit disabled; privileged instruction in user mode.
- R2: On the full core, a bundle constraint violation by a float or media instruction raises kind 2 (FP exception) with FP trap type 4 (sequence error). Any other constraint violation raises kind 1 (illegal instruction).
- R3: On the full core, a not-implemented float instruction raises kind 2 with FP trap type 3 (unimplemented FP op). A not-implemented media instruction that is not float raises no trap and requests a media trap-type write of value 3 (unimplemented media op). Any other not-implemented instruction raises kind 1.
- R4: On the reduced core (core_reduced=1), every constraint violation and every not-implemented case raises kind 1, with FP trap type 0 and no media write.
- R5: With the FP unit disabled, kind 3 (FP disabled) is raised for a float instruction, or for an FP-register access while the media unit is also disabled. Otherwise nothing is raised and the media and privilege checks are skipped.
- R6: With the FP unit enabled and the media unit disabled, kind 4 (media disabled) is raised for a media or media-trap instruction. Otherwise nothing is raised and the privilege check is skipped.
- R7: With both units enabled, a privileged instruction raises kind 5 (privileged) when mode_super=0 and nothing when mode_super=1.
- R8: The media trap-type write strobe fires only while media_tt_cur is 0 (none). When the field is non-zero, the case in R3 raises nothing and writes nothing.
- R9: A trap and a media write never occur together. When no trap is raised, exc_kind and exc_fp_tt are 0. exc_fp_tt is non-zero only with kind 2. media_tt_wdata is 3 with the strobe and 0 without it.
- R10: With parameter ALLOW_REDUCED=0, the core_reduced input has no effect and the block always behaves as the full core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_bundle_err | input | 1 | Instruction violates bundle constraints |
| insn_nonexc | input | 1 | Non-excepting instruction form |
| insn_cond | input | 1 | Conditional instruction form |
| insn_float | input | 1 | Floating-point instruction |
| insn_media | input | 1 | Media instruction |
| insn_mtrap | input | 1 | Media trap instruction |
| insn_fr_acc | input | 1 | Instruction accesses an FP register |
| insn_priv | input | 1 | Privileged instruction |
| mode_nonexc_en | input | 1 | Non-excepting mode enabled |
| mode_cond_en | input | 1 | Conditional mode enabled |
| mode_fp_en | input | 1 | FP unit enabled |
| mode_media_en | input | 1 | Media unit enabled |
| mode_super | input | 1 | Supervisor mode |
| core_reduced | input | 1 | Reduced core variant select |
| media_tt_cur | input | MTT_W (3) | Current media trap-type field |
| exc_valid | output | 1 | A trap is raised |
| exc_kind | output | KIND_W (5) | Trap kind code |
| exc_fp_tt | output | FTT_W (3) | FP trap type for kind 2 |
| media_tt_we | output | 1 | Media trap-type write strobe |
| media_tt_wdata | output | MTT_W (3) | Media trap-type write value |

## Verification
The bench sweeps every combination of attributes, modes, variant and empty or occupied media field, so that masking effects between checks are covered. One such effect is an FP-disabled core hiding a privilege fault; a chain written with independent ifs would raise the later fault there. A float instruction that is also media must take the FP path on a not-implemented fault. Swapping those tests would produce a silent media write where a trap is due. An occupied media field must swallow the media case entirely, and a design that still strobed would overwrite the first recorded cause. A second instance, with the reduced option compiled out, shows that the variant input is then ignored.

// File: rtl/issue_exc_pkg.sv
package issue_exc_pkg;

   // Trap kind codes
   localparam int K_ILLEGAL = 1;
   localparam int K_FP_EXC  = 2;
   localparam int K_FP_DIS  = 3;
   localparam int K_MP_DIS  = 4;
   localparam int K_PRIV    = 5;

   // FP trap types
   localparam int FTT_NONE  = 0;
   localparam int FTT_UNIMP = 3;
   localparam int FTT_SEQ   = 4;

   // Media trap types
   localparam int MTT_NONE  = 0;
   localparam int MTT_UNIMP = 3;

   typedef struct packed {
      logic bundle_err;
      logic nonexc;
      logic cond;
      logic is_float;
      logic is_media;
      logic mtrap;
      logic fr_acc;
      logic priv;
   } insn_attr_t;

   typedef struct packed {
      logic nonexc_en;
      logic cond_en;
      logic fp_en;
      logic media_en;
      logic sup;
   } issue_mode_t;

   typedef enum logic [2:0] {
      CAT_NONE,
      CAT_CONSTR,
      CAT_NOTIMPL,
      CAT_FPDIS,
      CAT_MPDIS,
      CAT_PRIV
   } fault_cat_e;

endpackage

// File: rtl/issue_exc_prio.sv
module issue_exc_prio
   import issue_exc_pkg::*;
(
   input  insn_attr_t  attr,
   input  issue_mode_t mode,
   output fault_cat_e  cat
);

   logic notimpl;

   assign notimpl = (attr.nonexc && !mode.nonexc_en) || (attr.cond && !mode.cond_en);

   // Ordered chain: an enable check that matches but raises nothing
   // still stops the chain.
   always_comb begin
      cat = CAT_NONE;
      if (attr.bundle_err) begin
         cat = CAT_CONSTR;
      end else if (notimpl) begin
         cat = CAT_NOTIMPL;
      end else if (!mode.fp_en) begin
         if (attr.is_float || (attr.fr_acc && !mode.media_en))
            cat = CAT_FPDIS;
      end else if (!mode.media_en) begin
         if (attr.is_media || attr.mtrap)
            cat = CAT_MPDIS;
      end else if (attr.priv && !mode.sup) begin
         cat = CAT_PRIV;
      end
   end

endmodule

// File: rtl/issue_exc_map.sv
module issue_exc_map
   import issue_exc_pkg::*;
#(
   parameter int KIND_W = 5,
   parameter int FTT_W  = 3,
   parameter int MTT_W  = 3
) (
   input  fault_cat_e        cat,
   input  logic              is_float,
   input  logic              is_media,
   input  logic              reduced,
   input  logic [MTT_W-1:0]  mtt_cur,
   output logic              valid,
   output logic [KIND_W-1:0] kind,
   output logic [FTT_W-1:0]  ftt,
   output logic              mtt_we,
   output logic [MTT_W-1:0]  mtt_wdata
);

   localparam logic [KIND_W-1:0] C_ILLEGAL = KIND_W'(K_ILLEGAL);
   localparam logic [KIND_W-1:0] C_FP_EXC  = KIND_W'(K_FP_EXC);
   localparam logic [KIND_W-1:0] C_FP_DIS  = KIND_W'(K_FP_DIS);
   localparam logic [KIND_W-1:0] C_MP_DIS  = KIND_W'(K_MP_DIS);
   localparam logic [KIND_W-1:0] C_PRIV    = KIND_W'(K_PRIV);
   localparam logic [FTT_W-1:0]  C_FTT_UN  = FTT_W'(FTT_UNIMP);
   localparam logic [FTT_W-1:0]  C_FTT_SEQ = FTT_W'(FTT_SEQ);
   localparam logic [MTT_W-1:0]  C_MTT_NO  = MTT_W'(MTT_NONE);
   localparam logic [MTT_W-1:0]  C_MTT_UN  = MTT_W'(MTT_UNIMP);

   logic mtt_empty;
   assign mtt_empty = (mtt_cur == C_MTT_NO);

   always_comb begin
      valid     = 1'b0;
      kind      = '0;
      ftt       = '0;
      mtt_we    = 1'b0;
      mtt_wdata = '0;
      unique case (cat)
         CAT_CONSTR: begin
            valid = 1'b1;
            if (!reduced && (is_float || is_media)) begin
               kind = C_FP_EXC;
               ftt  = C_FTT_SEQ;
            end else begin
               kind = C_ILLEGAL;
            end
         end
         CAT_NOTIMPL: begin
            if (reduced) begin
               valid = 1'b1;
               kind  = C_ILLEGAL;
            end else if (is_float) begin
               valid = 1'b1;
               kind  = C_FP_EXC;
               ftt   = C_FTT_UN;
            end else if (is_media) begin
               mtt_we    = mtt_empty;
               mtt_wdata = mtt_empty ? C_MTT_UN : '0;
            end else begin
               valid = 1'b1;
               kind  = C_ILLEGAL;
            end
         end
         CAT_FPDIS: begin
            valid = 1'b1;
            kind  = C_FP_DIS;
         end
         CAT_MPDIS: begin
            valid = 1'b1;
            kind  = C_MP_DIS;
         end
         CAT_PRIV: begin
            valid = 1'b1;
            kind  = C_PRIV;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/issue_exc_check.sv
module issue_exc_check
   import issue_exc_pkg::*;
#(
   parameter int KIND_W        = 5,
   parameter int FTT_W         = 3,
   parameter int MTT_W         = 3,
   parameter bit ALLOW_REDUCED = 1'b1
) (
   input  logic              insn_bundle_err,
   input  logic              insn_nonexc,
   input  logic              insn_cond,
   input  logic              insn_float,
   input  logic              insn_media,
   input  logic              insn_mtrap,
   input  logic              insn_fr_acc,
   input  logic              insn_priv,
   input  logic              mode_nonexc_en,
   input  logic              mode_cond_en,
   input  logic              mode_fp_en,
   input  logic              mode_media_en,
   input  logic              mode_super,
   input  logic              core_reduced,
   input  logic [MTT_W-1:0]  media_tt_cur,
   output logic              exc_valid,
   output logic [KIND_W-1:0] exc_kind,
   output logic [FTT_W-1:0]  exc_fp_tt,
   output logic              media_tt_we,
   output logic [MTT_W-1:0]  media_tt_wdata
);

   if (KIND_W < 3) begin : g_bad_kind_w
      $error("KIND_W too narrow for trap kind codes");
   end
   if (FTT_W < 3) begin : g_bad_ftt_w
      $error("FTT_W too narrow for FP trap types");
   end
   if (MTT_W < 2) begin : g_bad_mtt_w
      $error("MTT_W too narrow for media trap types");
   end

   insn_attr_t  attr;
   issue_mode_t mode;
   fault_cat_e  cat;
   logic        reduced;

   assign attr = '{bundle_err: insn_bundle_err, nonexc: insn_nonexc, cond: insn_cond,
                   is_float: insn_float, is_media: insn_media, mtrap: insn_mtrap,
                   fr_acc: insn_fr_acc, priv: insn_priv};
   assign mode = '{nonexc_en: mode_nonexc_en, cond_en: mode_cond_en, fp_en: mode_fp_en,
                   media_en: mode_media_en, sup: mode_super};

   if (ALLOW_REDUCED) begin : g_variant_sel
      assign reduced = core_reduced;
   end else begin : g_full_only
      assign reduced = 1'b0;
   end

   issue_exc_prio u_prio (
      .attr (attr),
      .mode (mode),
      .cat  (cat)
   );

   issue_exc_map #(
      .KIND_W (KIND_W),
      .FTT_W  (FTT_W),
      .MTT_W  (MTT_W)
   ) u_map (
      .cat       (cat),
      .is_float  (insn_float),
      .is_media  (insn_media),
      .reduced   (reduced),
      .mtt_cur   (media_tt_cur),
      .valid     (exc_valid),
      .kind      (exc_kind),
      .ftt       (exc_fp_tt),
      .mtt_we    (media_tt_we),
      .mtt_wdata (media_tt_wdata)
   );

endmodule

// File: rtl/issue_exc_check_sva.sv
module issue_exc_check_sva
   import issue_exc_pkg::*;
#(
   parameter int KIND_W = 5,
   parameter int FTT_W  = 3,
   parameter int MTT_W  = 3
) (
   input logic              insn_bundle_err,
   input logic              insn_priv,
   input logic              mode_fp_en,
   input logic              mode_media_en,
   input logic              mode_super,
   input logic [MTT_W-1:0]  media_tt_cur,
   input logic              exc_valid,
   input logic [KIND_W-1:0] exc_kind,
   input logic [FTT_W-1:0]  exc_fp_tt,
   input logic              media_tt_we
);

   always_comb begin
      assert_single_action_R9: assert (!(exc_valid && media_tt_we));
      if (!exc_valid)
         assert_idle_zero_R9: assert (exc_kind == '0 && exc_fp_tt == '0);
      if (exc_fp_tt != '0)
         assert_ftt_with_fp_R9: assert (exc_valid && exc_kind == KIND_W'(K_FP_EXC));
      if (insn_bundle_err)
         assert_constr_traps_R2: assert (exc_valid);
      if (exc_valid && exc_kind == KIND_W'(K_FP_DIS))
         assert_fpdis_mode_R5: assert (!mode_fp_en && !insn_bundle_err);
      if (exc_valid && exc_kind == KIND_W'(K_MP_DIS))
         assert_mpdis_mode_R6: assert (mode_fp_en && !mode_media_en);
      if (exc_valid && exc_kind == KIND_W'(K_PRIV))
         assert_priv_user_R7: assert (insn_priv && !mode_super && mode_fp_en && mode_media_en);
      if (media_tt_we)
         assert_tt_empty_R8: assert (media_tt_cur == MTT_W'(MTT_NONE));
   end

endmodule

bind issue_exc_check issue_exc_check_sva #(
   .KIND_W (KIND_W),
   .FTT_W  (FTT_W),
   .MTT_W  (MTT_W)
) u_sva (
   .insn_bundle_err (insn_bundle_err),
   .insn_priv       (insn_priv),
   .mode_fp_en      (mode_fp_en),
   .mode_media_en   (mode_media_en),
   .mode_super      (mode_super),
   .media_tt_cur    (media_tt_cur),
   .exc_valid       (exc_valid),
   .exc_kind        (exc_kind),
   .exc_fp_tt       (exc_fp_tt),
   .media_tt_we     (media_tt_we)
);

// File: tb/issue_exc_check_tb.sv
module issue_exc_check_tb;

   // stimulus vector bit positions
   localparam int B_ERR = 0, B_NONEXC = 1, B_COND = 2, B_FLOAT = 3, B_MEDIA = 4;
   localparam int B_MTRAP = 5, B_FRACC = 6, B_PRIV = 7, B_NEM = 8, B_CM = 9;
   localparam int B_EF = 10, B_EM = 11, B_SUP = 12, B_RED = 13, B_MTTNZ = 14;
   localparam int WATCHDOG_CYC = 150000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [14:0] v = '0;
   logic        exc_valid, media_tt_we, f_valid, f_we;
   logic [4:0]  exc_kind, f_kind;
   logic [2:0]  exc_fp_tt, media_tt_wdata, f_ftt, f_wdata;
   logic [2:0]  tt_cur;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   assign tt_cur = v[B_MTTNZ] ? 3'd2 : 3'd0;

   issue_exc_check u_dut (
      .insn_bundle_err (v[B_ERR]),   .insn_nonexc (v[B_NONEXC]), .insn_cond (v[B_COND]),
      .insn_float (v[B_FLOAT]),      .insn_media (v[B_MEDIA]),   .insn_mtrap (v[B_MTRAP]),
      .insn_fr_acc (v[B_FRACC]),     .insn_priv (v[B_PRIV]),     .mode_nonexc_en (v[B_NEM]),
      .mode_cond_en (v[B_CM]),       .mode_fp_en (v[B_EF]),      .mode_media_en (v[B_EM]),
      .mode_super (v[B_SUP]),        .core_reduced (v[B_RED]),   .media_tt_cur (tt_cur),
      .exc_valid (exc_valid), .exc_kind (exc_kind), .exc_fp_tt (exc_fp_tt),
      .media_tt_we (media_tt_we), .media_tt_wdata (media_tt_wdata)
   );

   issue_exc_check #(.ALLOW_REDUCED(1'b0)) u_dut_full (
      .insn_bundle_err (v[B_ERR]),   .insn_nonexc (v[B_NONEXC]), .insn_cond (v[B_COND]),
      .insn_float (v[B_FLOAT]),      .insn_media (v[B_MEDIA]),   .insn_mtrap (v[B_MTRAP]),
      .insn_fr_acc (v[B_FRACC]),     .insn_priv (v[B_PRIV]),     .mode_nonexc_en (v[B_NEM]),
      .mode_cond_en (v[B_CM]),       .mode_fp_en (v[B_EF]),      .mode_media_en (v[B_EM]),
      .mode_super (v[B_SUP]),        .core_reduced (v[B_RED]),   .media_tt_cur (tt_cur),
      .exc_valid (f_valid), .exc_kind (f_kind), .exc_fp_tt (f_ftt),
      .media_tt_we (f_we), .media_tt_wdata (f_wdata)
   );

   // {valid, kind[4:0], ftt[2:0], we, wdata[2:0]}
   function automatic logic [12:0] pack(bit vd, int k, int t, bit w, int wd);
      return {vd, 5'(k), 3'(t), w, 3'(wd)};
   endfunction

   // behavioural expectation from the requirement list
   function automatic void expect_of(input logic [14:0] s, input bit force_full,
                                     output logic [12:0] e, output string tag);
      bit red = s[B_RED] && !force_full;
      bit empty = !s[B_MTTNZ];
      e = '0;
      tag = "R9";
      if (s[B_ERR]) begin
         tag = red ? "R4" : "R2";
         e = (!red && (s[B_FLOAT] || s[B_MEDIA])) ? pack(1, 2, 4, 0, 0) : pack(1, 1, 0, 0, 0);
      end else if ((s[B_NONEXC] && !s[B_NEM]) || (s[B_COND] && !s[B_CM])) begin
         if (red) begin tag = "R4"; e = pack(1, 1, 0, 0, 0); end
         else if (s[B_FLOAT]) begin tag = "R3"; e = pack(1, 2, 3, 0, 0); end
         else if (s[B_MEDIA]) begin
            tag = empty ? "R3" : "R8";
            e = empty ? pack(0, 0, 0, 1, 3) : '0;
         end else begin tag = "R3"; e = pack(1, 1, 0, 0, 0); end
      end else if (!s[B_EF]) begin
         tag = "R5";
         if (s[B_FLOAT] || (s[B_FRACC] && !s[B_EM])) e = pack(1, 3, 0, 0, 0);
      end else if (!s[B_EM]) begin
         tag = "R6";
         if (s[B_MEDIA] || s[B_MTRAP]) e = pack(1, 4, 0, 0, 0);
      end else if (s[B_PRIV]) begin
         tag = "R7";
         if (!s[B_SUP]) e = pack(1, 5, 0, 0, 0);
      end
   endfunction

   task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s stim=%h actual=%h expected=%h", tag, v, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic apply(logic [14:0] s);
      @(posedge clk);
      v = s;
      @(negedge clk);
   endtask

   function automatic logic [12:0] dut_out();
      return {exc_valid, exc_kind, exc_fp_tt, media_tt_we, media_tt_wdata};
   endfunction

   task automatic directed(string tag, logic [14:0] s, logic [12:0] exp);
      apply(s);
      check(tag, dut_out(), exp);
   endtask

   initial begin
      logic [12:0] e;
      string tg;
      // idle state with all inputs low: R9
      directed("R9", 15'd0, 13'd0);
      // R1: constraint beats privilege
      directed("R1", 15'((1<<B_ERR)|(1<<B_PRIV)|(1<<B_EF)|(1<<B_EM)), pack(1, 1, 0, 0, 0));
      // R1: not-implemented beats FP disabled
      directed("R1", 15'((1<<B_NONEXC)|(1<<B_FLOAT)), pack(1, 2, 3, 0, 0));
      directed("R2", 15'((1<<B_ERR)|(1<<B_MEDIA)|(1<<B_EF)|(1<<B_EM)), pack(1, 2, 4, 0, 0));
      directed("R4", 15'((1<<B_ERR)|(1<<B_MEDIA)|(1<<B_EF)|(1<<B_EM)|(1<<B_RED)), pack(1, 1, 0, 0, 0));
      directed("R3", 15'((1<<B_COND)|(1<<B_MEDIA)|(1<<B_EF)|(1<<B_EM)), pack(0, 0, 0, 1, 3));
      directed("R8", 15'((1<<B_COND)|(1<<B_MEDIA)|(1<<B_EF)|(1<<B_EM)|(1<<B_MTTNZ)), 13'd0);
      directed("R5", 15'(1<<B_FRACC), pack(1, 3, 0, 0, 0));
      directed("R5", 15'(1<<B_PRIV), 13'd0);
      directed("R6", 15'((1<<B_MTRAP)|(1<<B_EF)), pack(1, 4, 0, 0, 0));
      directed("R7", 15'((1<<B_PRIV)|(1<<B_EF)|(1<<B_EM)), pack(1, 5, 0, 0, 0));
      directed("R7", 15'((1<<B_PRIV)|(1<<B_EF)|(1<<B_EM)|(1<<B_SUP)), 13'd0);

      // exhaustive sweep, both instances compared every clock
      for (int i = 0; i < 32768; i++) begin
         apply(15'(i));
         expect_of(15'(i), 1'b0, e, tg);
         check(tg, dut_out(), e);
         expect_of(15'(i), 1'b1, e, tg);
         check("R10", {f_valid, f_kind, f_ftt, f_we, f_wdata}, e);
      end
      finish_run();
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

endmodule